// File: doc/BRIEF.md
# Cascaded DMA Channel Mask and Status Unit

This unit keeps the per-channel enable masks and the status bits for two four-channel DMA controllers that are chained together, eight channels in all. Channel 0 of the second (upper) controller carries the cascade from the first (lower) controller. Each channel's request, whether it comes from its hardware line or from a software request bit, is gated by that channel's mask. The gated vector is registered and then goes to a priority arbiter. Because the lower controller is reached through the cascade channel, masking upper channel 0 silences all four lower channels.

Software reaches the unit through a small register port. A controller select and a register select choose one of four operations: write all four masks, clear all four masks, set or clear one mask bit, or read the status. Terminal-count pulses from the count logic set sticky status bits. They also set the channel's mask automatically, unless that channel runs in autoinitialize mode. Reading the status register returns the pending-request nibble together with the terminal-count nibble, and then clears the terminal-count nibble.

Top module: `dma_mask_status`

## Requirements
- R1: Register select 0 (write-all-mask) takes wdata bits 3:0 as the masks of channels 0..3 of the selected controller, where 1 means disabled. A read with select 0 returns {4'b0000, mask}, so the upper nibble reads 0 even if 1s were written to it. Controller select 0 is the lower controller (global channels 0..3) and 1 is the upper controller (global channels 4..7). Read data appears in the cycle after the read strobe and holds until the next read.
- R2: A synchronous reset sets every mask bit to 1, clears every status bit and clears the gated outputs. A master clear of one controller sets that controller's four masks and clears its terminal-count bits.
- R3: A terminal-count pulse sets that channel's mask to 1 on the next edge, unless the channel's autoinitialize flag is high. With the flag high, the mask is left unchanged.
- R4: A set mask bit stays set until a clear-mask command (select 1), a write-all-mask or a single-mask write clears it. A clear-mask command clears only the four masks of the addressed controller.
- R5: Select 2 (single-mask) uses wdata bits 1:0 to pick the channel and wdata bit 2 as the new mask value. The other three masks are left unchanged.
- R6: While the mask of upper channel 0 (global channel 4) is set, gated outputs 3:0 are 0.
- R7: Gated output n, registered one cycle, equals (hw_req[n] | sw_req[n]) & ~mask[n]. For n < 4 it is also ANDed with ~mask[4].
- R8: A status read (select 3) returns in bits 7:4 the unmasked (hw_req | sw_req) of the controller's four channels. The bit for upper channel 0 has no defined value.
- R9: Status bits 3:0 are sticky terminal-count flags. A status read clears them, except for a flag whose pulse arrives in the same cycle as the read, which stays set.
- R10: When a terminal-count mask set and a register write hit the same mask bit in the same cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclr_i | input | 2 | Per-controller master clear |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| ctrl_sel_i | input | 1 | Controller select (0 lower, 1 upper) |
| reg_sel_i | input | 2 | Operation: 0 mask-all, 1 clear-mask, 2 single-mask, 3 status |
| wdata_i | input | 8 | Write data |
| hw_req_i | input | 8 | Hardware request lines |
| sw_req_i | input | 8 | Software request bits |
| tc_pulse_i | input | 8 | Terminal-count pulses |
| autoinit_i | input | 8 | Autoinitialize flags |
| req_gated_o | output | 8 | Registered gated requests to the arbiter |
| rdata_o | output | 8 | Registered read data |

## Verification
Directed sequences first drive every request high with all masks open, then close the cascade channel alone. This separates the per-channel masking from the cascade suppression. A terminal-count pulse is placed in the same cycle as a clear-mask write and as a status read, which shows that the automatic set wins and that a same-cycle flag survives the read-clear. The same pulse is then repeated with autoinitialize on to show that the mask stays open. A seeded random phase mixes all four operations with sparse pulses and master clears, and a cycle-level model in the bench catches any ordering mistake between writes, automatic sets and clears.

// File: rtl/dma_ms_pkg.sv
package dma_ms_pkg;
  typedef enum logic [1:0] {
    REG_MASK_ALL = 2'd0,
    REG_MASK_CLR = 2'd1,
    REG_MASK_ONE = 2'd2,
    REG_STATUS   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_mask_bank.sv
module dma_mask_bank
  import dma_ms_pkg::*;
#(
  parameter int CH = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mclr,
  input  logic          wr_hit,
  input  logic          rd_stat_hit,
  input  reg_sel_e      reg_sel,
  input  logic [DW-1:0] wdata,
  input  logic [CH-1:0] tc_pulse,
  input  logic [CH-1:0] autoinit,
  output logic [CH-1:0] mask_q,
  output logic [CH-1:0] tc_q
);
  localparam int SEL_W = (CH > 1) ? $clog2(CH) : 1;

  logic [CH-1:0] mask_nxt;

  // per-channel next mask: register write first, automatic set overrides (R10)
  function automatic logic next_mask_bit(
    input logic          cur,
    input logic          hit,
    input reg_sel_e      sel,
    input logic [DW-1:0] d,
    input logic [SEL_W-1:0] idx,
    input logic          tc,
    input logic          ai
  );
    logic v;
    v = cur;
    if (hit) begin
      case (sel)
        REG_MASK_ALL: v = d[idx];
        REG_MASK_CLR: v = 1'b0;
        REG_MASK_ONE: if (d[SEL_W-1:0] == idx) v = d[SEL_W];
        default:      v = cur;
      endcase
    end
    if (tc && !ai) v = 1'b1;
    return v;
  endfunction

  for (genvar i = 0; i < CH; i++) begin : g_ch
    localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
    assign mask_nxt[i] = next_mask_bit(mask_q[i], wr_hit, reg_sel, wdata, IDX,
                                       tc_pulse[i], autoinit[i]);

    assert_tc_sets_mask_R3: assert property (@(posedge clk) disable iff (rst)
      (tc_pulse[i] && !autoinit[i]) |=> mask_q[i]);

    assert_mask_holds_R4: assert property (@(posedge clk) disable iff (rst)
      (mask_q[i] && !wr_hit && !mclr) |=> mask_q[i]);

    assert_tc_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (tc_pulse[i] && !mclr) |=> tc_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      mask_q <= '1;
      tc_q   <= '0;
    end else begin
      mask_q <= mask_nxt;
      tc_q   <= (rd_stat_hit ? '0 : tc_q) | tc_pulse;
    end
  end

  assert_clear_state_R2: assert property (@(posedge clk)
    (rst || mclr) |=> (mask_q == '1 && tc_q == '0));

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int CH    = 4,
  parameter int NCH   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] raw_req,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] gated_q
);
  logic [NCH-1:0] gated_d;

  for (genvar n = 0; n < NCH; n++) begin : g_gate
    if (n < CH) begin : g_lower
      // lower controller is reached through upper channel 0
      assign gated_d[n] = raw_req[n] & ~mask[n] & ~mask[CH];
    end else begin : g_upper
      assign gated_d[n] = raw_req[n] & ~mask[n];
    end

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      mask[n] |=> !gated_q[n]);
  end

  always_ff @(posedge clk) begin
    if (rst) gated_q <= '0;
    else     gated_q <= gated_d;
  end

  assert_cascade_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    mask[CH] |=> (gated_q[CH-1:0] == '0));

endmodule

// File: rtl/dma_status_read.sv
module dma_status_read
  import dma_ms_pkg::*;
#(
  parameter int CH  = 4,
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic           ctrl_sel,
  input  reg_sel_e       reg_sel,
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] tc,
  output logic [DW-1:0]  rdata_q
);
  logic [CH-1:0] pend_s, mask_s, tc_s;
  logic [DW-1:0] rdata_d;

  assign pend_s = pend[ctrl_sel*CH +: CH];
  assign mask_s = mask[ctrl_sel*CH +: CH];
  assign tc_s   = tc[ctrl_sel*CH +: CH];

  always_comb begin
    rdata_d = '0;
    case (reg_sel)
      REG_STATUS:   rdata_d = DW'({pend_s, tc_s});
      REG_MASK_ALL: rdata_d = DW'(mask_s);
      default:      rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assert_mask_read_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == REG_MASK_ALL) |=> (rdata_q[DW-1:CH] == '0));

  assert_rdata_holds_R1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));

endmodule

// File: rtl/dma_mask_status.sv
module dma_mask_status
  import dma_ms_pkg::*;
#(
  parameter int CH_PER_CTRL = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [1:0]                           mclr_i,
  input  logic                                 wr_en_i,
  input  logic                                 rd_en_i,
  input  logic                                 ctrl_sel_i,
  input  logic [1:0]                           reg_sel_i,
  input  logic [2*CH_PER_CTRL-1:0]             wdata_i,
  input  logic [2*CH_PER_CTRL-1:0]             hw_req_i,
  input  logic [2*CH_PER_CTRL-1:0]             sw_req_i,
  input  logic [2*CH_PER_CTRL-1:0]             tc_pulse_i,
  input  logic [2*CH_PER_CTRL-1:0]             autoinit_i,
  output logic [2*CH_PER_CTRL-1:0]             req_gated_o,
  output logic [2*CH_PER_CTRL-1:0]             rdata_o
);
  localparam int NCTRL = 2;
  localparam int CH    = CH_PER_CTRL;
  localparam int NCH   = NCTRL * CH;
  localparam int DW    = 2 * CH;

  reg_sel_e       sel;
  logic [NCH-1:0] raw_req;
  logic [NCH-1:0] mask_all;
  logic [NCH-1:0] tc_all;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign raw_req = hw_req_i | sw_req_i;

  for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
    logic hit_sel;
    assign hit_sel = (ctrl_sel_i == c[0]);

    dma_mask_bank #(.CH(CH), .DW(DW)) u_bank (
      .clk         (clk),
      .rst         (rst),
      .mclr        (mclr_i[c]),
      .wr_hit      (wr_en_i && hit_sel),
      .rd_stat_hit (rd_en_i && hit_sel && sel == REG_STATUS),
      .reg_sel     (sel),
      .wdata       (wdata_i),
      .tc_pulse    (tc_pulse_i[c*CH +: CH]),
      .autoinit    (autoinit_i[c*CH +: CH]),
      .mask_q      (mask_all[c*CH +: CH]),
      .tc_q        (tc_all[c*CH +: CH])
    );
  end

  dma_req_gate #(.CH(CH), .NCH(NCH)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .raw_req (raw_req),
    .mask    (mask_all),
    .gated_q (req_gated_o)
  );

  dma_status_read #(.CH(CH), .NCH(NCH), .DW(DW)) u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en_i),
    .ctrl_sel (ctrl_sel_i),
    .reg_sel  (sel),
    .pend     (raw_req),
    .mask     (mask_all),
    .tc       (tc_all),
    .rdata_q  (rdata_o)
  );

  assert_reset_outputs_R2: assert property (@(posedge clk)
    rst |=> (req_gated_o == '0 && rdata_o == '0));

endmodule

// File: tb/dma_mask_status_bench.sv
module dma_mask_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mclr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, csel = 1'b0;
  logic [1:0] rsel = '0;
  logic [7:0] wdata = '0, hreq = '0, sreq = '0, tcp = '0, ainit = '0;
  logic [7:0] gated, rdata;

  int n_chk = 0, n_fail = 0;

  // reference state
  logic [7:0] m_mask = 8'hFF, m_tc = '0, m_gated = '0, m_rdata = '0;
  logic       m_rd_last = 1'b0, m_rd_csel = 1'b0;
  logic [1:0] m_rd_sel = '0;

  always #2 clk = ~clk;

  dma_mask_status u_dma_mask_status (
    .clk(clk), .rst(rst), .mclr_i(mclr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .ctrl_sel_i(csel), .reg_sel_i(rsel), .wdata_i(wdata), .hw_req_i(hreq),
    .sw_req_i(sreq), .tc_pulse_i(tcp), .autoinit_i(ainit),
    .req_gated_o(gated), .rdata_o(rdata)
  );

  function automatic logic [7:0] f_gate(input logic [7:0] req, input logic [7:0] m);
    logic [7:0] g;
    g = req & ~m;
    if (m[4]) g[3:0] = 4'h0;
    return g;
  endfunction

  function automatic logic [3:0] f_mask_nib(input logic [3:0] cur, input logic hit,
                                            input logic [1:0] s, input logic [7:0] d,
                                            input logic [3:0] tc, input logic [3:0] ai);
    logic [3:0] v;
    v = cur;
    if (hit) begin
      if (s == 2'd0) v = d[3:0];
      else if (s == 2'd1) v = 4'h0;
      else if (s == 2'd2) v[d[1:0]] = d[2];
    end
    return v | (tc & ~ai);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mask = 8'hFF; m_tc = '0; m_gated = '0; m_rdata = '0; m_rd_last = 1'b0;
    end else begin
      logic [7:0] req;
      logic [3:0] nib;
      req = hreq | sreq;
      m_gated = f_gate(req, m_mask);
      m_rd_last = rd_en; m_rd_csel = csel; m_rd_sel = rsel;
      if (rd_en) begin
        if (rsel == 2'd3) m_rdata = csel ? {req[7:4], m_tc[7:4]} : {req[3:0], m_tc[3:0]};
        else if (rsel == 2'd0) m_rdata = {4'h0, csel ? m_mask[7:4] : m_mask[3:0]};
        else m_rdata = 8'h00;
      end
      for (int c = 0; c < 2; c++) begin
        if (mclr[c]) begin
          m_mask[c*4 +: 4] = 4'hF;
          m_tc[c*4 +: 4] = 4'h0;
        end else begin
          nib = f_mask_nib(m_mask[c*4 +: 4], wr_en && (csel == c[0]), rsel, wdata,
                           tcp[c*4 +: 4], ainit[c*4 +: 4]);
          m_mask[c*4 +: 4] = nib;
          m_tc[c*4 +: 4] = ((rd_en && rsel == 2'd3 && csel == c[0]) ? 4'h0 : m_tc[c*4 +: 4])
                           | tcp[c*4 +: 4];
        end
      end
    end
  end

  task automatic expect8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // model comparison, run at every negative edge after a clock
  task automatic model_check();
    expect8("R7 gated requests (R3 R4 R5 R6 R10 mask state)", gated, m_gated);
    if (m_rd_last) begin
      logic [7:0] a, e;
      a = rdata; e = m_rdata;
      if (m_rd_sel == 2'd3 && m_rd_csel) begin a[4] = 1'b0; e[4] = 1'b0; end
      expect8(m_rd_sel == 2'd3 ? "R8 R9 status read" : "R1 register read", a, e);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_check();
  endtask

  task automatic do_wr(input logic c, input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; csel = c; rsel = s; wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic c, input logic [1:0] s);
    rd_en = 1'b1; csel = c; rsel = s;
    cyc();
    rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cyc();
    expect8("R2 gated after reset", gated, 8'h00);
    do_rd(1'b0, 2'd3);
    expect8("R2 status after reset", rdata, 8'h00);
    do_rd(1'b1, 2'd0);
    expect8("R2 masks after reset", rdata, 8'h0F);
    do_wr(1'b0, 2'd0, 8'hF0);
    do_rd(1'b0, 2'd0);
    expect8("R1 mask-all write, upper bits read 0", rdata, 8'h00);
    do_wr(1'b1, 2'd1, 8'h00);
    hreq = 8'hFF;
    cyc(); cyc();
    expect8("R7 all open", gated, 8'hFF);
    do_wr(1'b1, 2'd2, 8'h04);
    cyc();
    expect8("R6 cascade mask blocks lower", gated, 8'hE0);
    do_rd(1'b1, 2'd0);
    expect8("R5 single-mask write", rdata, 8'h01);
    do_wr(1'b1, 2'd1, 8'h00);
    cyc();
    expect8("R4 clear-mask reopens", gated, 8'hFF);
    tcp = 8'h04;
    do_wr(1'b0, 2'd1, 8'h00);
    tcp = 8'h00;
    cyc();
    expect8("R10 automatic set wins", gated, 8'hFB);
    ainit = 8'h08; tcp = 8'h08;
    cyc();
    tcp = 8'h00; ainit = 8'h00;
    do_rd(1'b0, 2'd0);
    expect8("R3 mask set only without autoinit", rdata, 8'h04);
    tcp = 8'h02;
    do_rd(1'b0, 2'd3);
    tcp = 8'h00;
    expect8("R9 status with two flags", rdata, 8'hFC);
    do_rd(1'b0, 2'd3);
    expect8("R9 same-cycle flag survives read", rdata, 8'hF2);
    do_rd(1'b0, 2'd3);
    expect8("R9 flags cleared by read", rdata, 8'hF0);
    hreq = 8'h00; sreq = 8'h02;
    do_rd(1'b0, 2'd3);
    expect8("R8 software request pending", rdata, 8'h20);
    mclr = 2'b01;
    cyc();
    mclr = 2'b00;
    do_rd(1'b0, 2'd0);
    expect8("R2 master clear sets masks", rdata, 8'h0F);

    for (int k = 0; k < 4000; k++) begin
      hreq  = 8'($urandom);
      sreq  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      tcp   = (($urandom % 8) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      if (($urandom % 32) == 0) ainit = 8'($urandom);
      mclr  = (($urandom % 64) == 0) ? 2'($urandom) : 2'b00;
      wr_en = (($urandom % 3) == 0);
      rd_en = !wr_en && (($urandom % 3) == 0);
      csel  = 1'($urandom);
      rsel  = 2'($urandom);
      wdata = 8'($urandom);
      cyc();
    end
    wr_en = 1'b0; rd_en = 1'b0; tcp = '0; mclr = '0;
    cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule